// File: doc/BRIEF.md
# Arithmetic Shift-Right Unit with Carry

This unit performs signed right shifts on a 64-bit operand, in a 32-bit word form and in a 64-bit doubleword form. The shift amount comes either from a register operand or from a short immediate field. Internally the operand is rotated right and then merged with sign fill under a generated mask. The bits the mask rejects are the bits that the shift drops. The carry flag is set when the source is negative and at least one dropped bit was a one. That value is written to both carry outputs. When the record bit is set, the unit also produces a four-bit condition field that classifies the result, together with a write enable for that field.

The unit takes one operation per clock and returns the registered result one cycle later. It never writes the overflow or sticky-overflow flags. It only passes the incoming sticky-overflow bit into the condition field.

Top module: `arithShiftRight`

## Requirements
- R1: With `opSel`=2'b00 (word, register amount), the count is `amtReg[4:0]`. The result is the low 32 bits of `src`, shifted right arithmetically and sign-extended to 64 bits. `src[63:32]` has no effect on any output.
- R2: With `opSel`=2'b00 and `amtReg[5]`=1, the result is 64 copies of `src[31]`. The carry is `src[31]` AND (`src[31:0]` nonzero).
- R3: With `opSel`=2'b01 (word, immediate amount), the count is `imm[4:0]` and no overshift exists. `imm[5]` and `amtReg` have no effect.
- R4: With `opSel`=2'b10 (doubleword, register amount), the count is `amtReg[5:0]` and the full 64-bit `src` is shifted arithmetically. When `amtReg[6]`=1, the result is 64 copies of `src[63]` and the carry is `src[63]` AND (`src` nonzero).
- R5: With `opSel`=2'b11 (doubleword, immediate amount), the count is `imm[5:0]` and `amtReg` has no effect.
- R6: `ca` and `ca32` always carry the same value: the sign bit AND (any one-bit shifted out). Word form considers only bits lost from `src[31:0]`. Doubleword form considers bits lost from all of `src`. A non-negative source never sets carry.
- R7: A count of zero returns the sign-extended low word in word form, or `src` unchanged in doubleword form, with carry 0.
- R8: When `recBit`=1, `cr0We` is 1 and `cr0` is {bit3 LT = result negative, bit2 GT = result positive and nonzero, bit1 EQ = result zero, bit0 = `soIn`}. When `recBit`=0, `cr0We` is 0.
- R9: An operation presented with `inValid`=1 at a rising edge appears on the outputs, with `outValid`=1, after that edge. A cycle with `inValid`=0 yields `outValid`=0 after the next edge.
- R10: While `rstN` is low, `outValid`, `cr0We`, `ca`, `ca32`, `result` and `cr0` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | bit1: doubleword form; bit0: immediate amount |
| src | input | 64 | Source operand |
| amtReg | input | 64 | Register shift amount |
| imm | input | 6 | Immediate shift amount |
| recBit | input | 1 | Request a condition-field update |
| soIn | input | 1 | Incoming sticky-overflow bit |
| outValid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Shifted result |
| ca | output | 1 | Carry flag |
| ca32 | output | 1 | 32-bit carry flag (same value as ca) |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr0We | output | 1 | Condition field write enable |

## Verification
The bench builds the unit at its only meaningful width: the default 64-bit datapath with a 32-bit word half and a 6-bit count. At that width it can reach the count boundaries that matter: 0, 1, 31 and 63. It also reaches the overshift bits at amount bits 5 and 6, and the immediate bit that word form must ignore. A reference model built on the language's signed shift operator predicts every result, with no rotate or mask. Operations go in back to back and with idle gaps, so the scoreboard also checks the one-cycle timing and the valid strobe.

// File: rtl/shrPkg.sv
package shrPkg;
  localparam int XLEN   = 64;
  localparam int HALF   = XLEN / 2;
  localparam int CNT_W  = $clog2(XLEN);
  localparam int HCNT_W = CNT_W - 1;

  typedef enum logic [1:0] {
    OP_WREG = 2'b00,
    OP_WIMM = 2'b01,
    OP_DREG = 2'b10,
    OP_DIMM = 2'b11
  } shrOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             dword;
    logic             killMask;
    logic [CNT_W-1:0] count;
    logic             recEn;
  } shrStrobe_t;

  typedef struct packed {
    logic [XLEN-1:0] value;
    logic            carry;
    logic [3:0]      cr0;
  } shrResult_t;
endpackage

// File: rtl/shrCtrl.sv
module shrCtrl
  import shrPkg::*;
(
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic [XLEN-1:0] amtReg,
  input  logic [CNT_W-1:0] imm,
  input  logic            recBit,
  output shrStrobe_t      strobe
);
  always_comb begin
    strobe.load     = inValid;
    strobe.recEn    = inValid & recBit;
    strobe.dword    = opSel[1];
    strobe.killMask = 1'b0;
    strobe.count    = '0;
    case (shrOp_e'(opSel))
      OP_WREG: begin
        strobe.count    = {1'b0, amtReg[HCNT_W-1:0]};
        strobe.killMask = amtReg[HCNT_W];
      end
      OP_WIMM: begin
        strobe.count    = {1'b0, imm[HCNT_W-1:0]};
      end
      OP_DREG: begin
        strobe.count    = amtReg[CNT_W-1:0];
        strobe.killMask = amtReg[CNT_W];
      end
      OP_DIMM: begin
        strobe.count    = imm;
      end
      default: begin
        strobe.count    = '0;
      end
    endcase
  end
endmodule

// File: rtl/shrRotMask.sv
module shrRotMask
  import shrPkg::*;
(
  input  logic             dword,
  input  logic             killMask,
  input  logic [CNT_W-1:0] count,
  input  logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  rotated,
  output logic [XLEN-1:0]  mask,
  output logic             sign
);
  localparam logic [CNT_W:0] HALF_SH = (CNT_W+1)'(HALF);
  localparam int REPS = XLEN / HALF;

  logic [HALF-1:0]   lowWord;
  logic [2*HALF-1:0] wPair;
  logic [HALF-1:0]   rotWord;
  logic [XLEN-1:0]   rotWordRep;
  logic [2*XLEN-1:0] dPair;
  logic [XLEN-1:0]   rotDword;
  logic [CNT_W:0]    wordShAmt;
  logic [XLEN-1:0]   allOnes;
  logic [XLEN-1:0]   wordMask;
  logic [XLEN-1:0]   dwordMask;

  assign lowWord = src[HALF-1:0];
  assign allOnes = '1;

  // 32-bit rotate right by count, i.e. rotate left by (width - count)
  always_comb begin
    wPair   = {lowWord, lowWord} >> count[HCNT_W-1:0];
    rotWord = wPair[HALF-1:0];
  end

  // copy the rotated word into every half of the datapath
  for (genvar g = 0; g < REPS; g++) begin : gRep
    assign rotWordRep[g*HALF +: HALF] = rotWord;
  end

  always_comb begin
    dPair    = {src, src} >> count;
    rotDword = dPair[XLEN-1:0];
  end

  // keep bits below the shifted-in sign region
  always_comb begin
    wordShAmt = HALF_SH + {1'b0, count};
    wordMask  = allOnes >> wordShAmt;
    dwordMask = allOnes >> count;
  end

  always_comb begin
    if (dword) begin
      rotated = rotDword;
      sign    = src[XLEN-1];
      mask    = killMask ? '0 : dwordMask;
    end else begin
      rotated = rotWordRep;
      sign    = src[HALF-1];
      mask    = killMask ? '0 : wordMask;
    end
  end
endmodule

// File: rtl/shrDatapath.sv
module shrDatapath
  import shrPkg::*;
(
  input  shrStrobe_t      strobe,
  input  logic [XLEN-1:0] src,
  input  logic            soIn,
  output shrResult_t      res
);
  logic [XLEN-1:0] rotated;
  logic [XLEN-1:0] mask;
  logic            sign;
  logic [XLEN-1:0] lost;
  logic            anyLost;
  logic            isNeg;
  logic            isZero;

  shrRotMask uRotMask (
    .dword    (strobe.dword),
    .killMask (strobe.killMask),
    .count    (strobe.count),
    .src      (src),
    .rotated  (rotated),
    .mask     (mask),
    .sign     (sign)
  );

  always_comb begin
    res.value = (rotated & mask) | ({XLEN{sign}} & ~mask);
    lost      = rotated & ~mask;
    anyLost   = strobe.dword ? (|lost) : (|lost[HALF-1:0]);
    res.carry = sign & anyLost;
    isNeg     = res.value[XLEN-1];
    isZero    = ~|res.value;
    res.cr0   = {isNeg, ~isNeg & ~isZero, isZero, soIn};
  end
endmodule

// File: rtl/arithShiftRight.sv
module arithShiftRight
  import shrPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic [63:0]     src,
  input  logic [63:0]     amtReg,
  input  logic [5:0]      imm,
  input  logic            recBit,
  input  logic            soIn,
  output logic            outValid,
  output logic [63:0]     result,
  output logic            ca,
  output logic            ca32,
  output logic [3:0]      cr0,
  output logic            cr0We
);
  shrStrobe_t strobe;
  shrResult_t dpRes;

  shrCtrl uCtrl (
    .inValid (inValid),
    .opSel   (opSel),
    .amtReg  (amtReg),
    .imm     (imm),
    .recBit  (recBit),
    .strobe  (strobe)
  );

  shrDatapath uDp (
    .strobe (strobe),
    .src    (src),
    .soIn   (soIn),
    .res    (dpRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      cr0We    <= 1'b0;
      result   <= '0;
      ca       <= 1'b0;
      ca32     <= 1'b0;
      cr0      <= '0;
    end else begin
      outValid <= strobe.load;
      cr0We    <= strobe.recEn;
      if (strobe.load) begin
        result <= dpRes.value;
        ca     <= dpRes.carry;
        ca32   <= dpRes.carry;
        cr0    <= dpRes.cr0;
      end
    end
  end
endmodule

// File: rtl/shrChecks.sv
module shrChecks
  import shrPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [1:0]      opSel,
  input logic [63:0]     src,
  input logic            recBit,
  input logic            soIn,
  input logic            outValid,
  input logic [63:0]     result,
  input logic            ca,
  input logic            ca32,
  input logic [3:0]      cr0,
  input logic            cr0We
);
  // R6: both carry flags agree
  a_r6_carry_pair: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (ca == ca32));

  // R6: non-negative word source never carries
  a_r6_word_pos_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel[1] && !src[HALF-1]) |=> !ca);

  // R6: non-negative doubleword source never carries
  a_r6_dword_pos_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel[1] && !src[XLEN-1]) |=> !ca);

  // R1: word forms yield a sign-extended word
  a_r1_word_sign_ext: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel[1]) |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

  // R8: exactly one of LT/GT/EQ when written
  a_r8_one_relation: assert property (@(posedge clk) disable iff (!rstN)
    cr0We |-> ($countones(cr0[3:1]) == 1));

  // R8: summary bit copied from the input
  a_r8_so_copy: assert property (@(posedge clk) disable iff (!rstN)
    cr0We |-> (cr0[0] == $past(soIn)));

  // R8: no write without the record bit
  a_r8_no_record: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !recBit) |=> !cr0We);

  // R9: valid follows the input one cycle later
  a_r9_valid_on: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r9_valid_off: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8: write enable only with a valid result
  a_r8_we_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    cr0We |-> outValid);
endmodule

bind arithShiftRight shrChecks chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .src      (src),
  .recBit   (recBit),
  .soIn     (soIn),
  .outValid (outValid),
  .result   (result),
  .ca       (ca),
  .ca32     (ca32),
  .cr0      (cr0),
  .cr0We    (cr0We)
);

// File: tb/arithShiftRight_test.sv
`timescale 1ns/1ps
module arithShiftRight_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [63:0] src = '0;
  logic [63:0] amtReg = '0;
  logic [5:0]  imm = '0;
  logic        recBit = 1'b0;
  logic        soIn = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic        ca, ca32;
  logic [3:0]  cr0;
  logic        cr0We;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        carry;
    logic        we;
    logic [3:0]  cr;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  arithShiftRight uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .src(src),
    .amtReg(amtReg), .imm(imm), .recBit(recBit), .soIn(soIn),
    .outValid(outValid), .result(result), .ca(ca), .ca32(ca32),
    .cr0(cr0), .cr0We(cr0We)
  );

  task automatic check64(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference: signed shift operator, no rotate or mask
  function automatic expItem_t model(logic [1:0] op, logic [63:0] s, logic [63:0] a,
                                     logic [5:0] im, logic rec, logic so, string tag);
    expItem_t e;
    int n;
    logic over, sgn;
    logic signed [63:0] sx;
    logic [63:0] lostMask;
    if (!op[1]) begin
      n    = op[0] ? int'(im[4:0]) : int'(a[4:0]);
      over = op[0] ? 1'b0 : a[5];
      sgn  = s[31];
      sx   = {{32{sgn}}, s[31:0]};
      if (over) begin
        e.res = {64{sgn}};
        e.carry = sgn && (s[31:0] != 0);
      end else begin
        e.res = sx >>> n;
        lostMask = (64'd1 << n) - 64'd1;
        e.carry = sgn && ((s[31:0] & lostMask[31:0]) != 0);
      end
    end else begin
      n    = op[0] ? int'(im) : int'(a[5:0]);
      over = op[0] ? 1'b0 : a[6];
      sgn  = s[63];
      sx   = s;
      if (over) begin
        e.res = {64{sgn}};
        e.carry = sgn && (s != 0);
      end else begin
        e.res = sx >>> n;
        lostMask = (64'd1 << n) - 64'd1;
        e.carry = sgn && ((s & lostMask) != 0);
      end
    end
    e.we  = rec;
    e.cr  = {e.res[63], !e.res[63] && (e.res != 0), e.res == 0, so};
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [1:0] op, logic [63:0] s, logic [63:0] a,
                       logic [5:0] im, logic rec, logic so, string tag);
    @(negedge clk);
    inValid = 1'b1; opSel = op; src = s; amtReg = a; imm = im;
    recBit = rec; soIn = so;
    expQ.push_back(model(op, s, a, im, rec, so, tag));
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      src = {$urandom, $urandom};
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected outValid got 1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check64(e.tag, "result", result, e.res);
        check64("R6", "ca", {63'd0, ca}, {63'd0, e.carry});
        check64("R6", "ca32", {63'd0, ca32}, {63'd0, e.carry});
        check64("R8", "cr0We", {63'd0, cr0We}, {63'd0, e.we});
        if (e.we) check64("R8", "cr0", {60'd0, cr0}, {60'd0, e.cr});
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R10", "outValid", {63'd0, outValid}, 64'd0);
    check64("R10", "cr0We", {63'd0, cr0We}, 64'd0);
    check64("R10", "ca/ca32", {62'd0, ca, ca32}, 64'd0);
    check64("R10", "result", result, 64'd0);
    check64("R10", "cr0", {60'd0, cr0}, 64'd0);
    rstN = 1'b1;

    // R1: word register amount, upper half of src irrelevant
    drive(2'b00, 64'h1234_5678_F000_00F0, 64'd4, 6'd0, 1'b1, 1'b0, "R1");
    drive(2'b00, 64'hDEAD_BEEF_F000_00F0, 64'd4, 6'd0, 1'b1, 1'b1, "R1");
    drive(2'b00, 64'h0000_0000_7FFF_FFFF, 64'hFF00_0000_0000_001F, 6'd0, 1'b0, 1'b0, "R1");
    // R2: word overshift
    drive(2'b00, 64'h0000_0000_8000_0001, 64'd35, 6'd0, 1'b1, 1'b0, "R2");
    drive(2'b00, 64'hFFFF_FFFF_8000_0000, 64'd32, 6'd0, 1'b1, 1'b0, "R2");
    drive(2'b00, 64'h0000_0000_1234_5678, 64'd63, 6'd0, 1'b1, 1'b1, "R2");
    // R3: immediate word, imm[5] ignored, amtReg ignored
    drive(2'b01, 64'h0000_0000_8000_000F, 64'd40, 6'b100011, 1'b1, 1'b0, "R3");
    drive(2'b01, 64'h0000_0000_8000_000F, 64'd0, 6'b000011, 1'b1, 1'b0, "R3");
    drive(2'b01, 64'hAAAA_0000_C000_0000, 64'd7, 6'd31, 1'b1, 1'b0, "R3");
    idle(2);
    // R4: doubleword register, overshift via bit 6
    drive(2'b10, 64'h8000_0000_0000_0003, 64'd1, 6'd0, 1'b1, 1'b0, "R4");
    drive(2'b10, 64'h8000_0000_0000_0000, 64'd63, 6'd0, 1'b1, 1'b0, "R4");
    drive(2'b10, 64'h8000_0000_0000_0001, 64'd64, 6'd0, 1'b1, 1'b0, "R4");
    drive(2'b10, 64'h4000_0000_0000_0001, 64'd70, 6'd0, 1'b1, 1'b1, "R4");
    // R5: doubleword immediate, amtReg ignored
    drive(2'b11, 64'hF000_0000_0001_0000, 64'd127, 6'd32, 1'b1, 1'b0, "R5");
    drive(2'b11, 64'hF000_0000_0000_0000, 64'd64, 6'd63, 1'b1, 1'b0, "R5");
    // R6: carry only from low word in word form
    drive(2'b00, 64'hFFFF_FFFF_8000_0000, 64'd8, 6'd0, 1'b1, 1'b0, "R6");
    drive(2'b00, 64'h0000_0000_7000_00FF, 64'd8, 6'd0, 1'b1, 1'b0, "R6");
    drive(2'b10, 64'hFFFF_FFFF_0000_0000, 64'd32, 6'd0, 1'b1, 1'b0, "R6");
    drive(2'b10, 64'hFFFF_FFFF_0000_0000, 64'd33, 6'd0, 1'b1, 1'b0, "R6");
    // R7: zero count
    drive(2'b00, 64'h5555_5555_9000_0001, 64'd0, 6'd0, 1'b1, 1'b0, "R7");
    drive(2'b10, 64'h9000_0000_0000_0001, 64'd0, 6'd0, 1'b1, 1'b1, "R7");
    drive(2'b11, 64'h0000_0000_0000_0000, 64'd0, 6'd0, 1'b1, 1'b0, "R7");
    // R8: record bit off
    drive(2'b10, 64'h8000_0000_0000_0000, 64'd4, 6'd0, 1'b0, 1'b1, "R8");
    idle(1);
    // R9: idle cycles produce no outValid
    @(negedge clk);
    check64("R9", "outValid after idle", {63'd0, outValid}, 64'd0);
    // mixed back-to-back operations
    for (int i = 0; i < 300; i++) begin
      drive(2'($urandom), {$urandom, $urandom}, {56'd0, 8'($urandom)},
            6'($urandom), 1'($urandom), 1'($urandom), "R9");
      if (($urandom % 7) == 0) idle(1);
    end
    idle(3);
    check64("R9", "pending items", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule